// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Controller

This block keeps two small pending vectors, one bit per processor, for up to four processors: one vector records interprocessor interrupts, the other records periodic timer interrupts. Each pending bit drives one interrupt line toward its processor. Software reaches the block through a simple 64-bit register port with four register selects. The first select is a combined control word, where one write can post interprocessor interrupts, retire pending interprocessor interrupts and retire pending timer interrupts, each through its own processor-mask field. The other three selects are dedicated registers that take a single processor mask in their low bits.

A single-cycle tick input, driven by an external periodic timer, marks a timer interrupt pending for every processor. Redundant requests and clears of interrupts that are not pending leave the state alone and raise a one-cycle warning pulse. Writes that carry no usable mask raise a one-cycle error pulse. A read of the control word reports both pending vectors and the number of the processor that is reading.

Top module: `ipitmr_ctl`

## Requirements
- R1: After reset both pending vectors are zero, so every `ipi_irq` and `tmr_irq` bit is low, and `warn_pulse` and `err_pulse` are low.
- R2: Bit n of `ipi_irq` and of `tmr_irq` equals processor n's pending bit; a write or tick sampled at a rising clock edge changes them at that edge, and the register port reads the same values.
- R3: A write with `reg_sel` = 0 (control word) posts interprocessor interrupts for the processors in `reg_wdata[15:12]`, clears pending interprocessor interrupts for the mask in `reg_wdata[11:8]` and clears pending timer interrupts for the mask in `reg_wdata[7:4]`, all in the same write.
- R4: Within one control-word write the request is applied before the clear, so a processor named in both bits 15:12 and bits 11:8 ends with no pending interprocessor interrupt.
- R5: A control-word write in which bits 15:4 are all zero changes no state; it pulses `err_pulse` for one cycle unless bit 28 is set, in which case it is an accepted no-op without an error.
- R6: Requesting an interprocessor interrupt for a processor that already has one pending, or clearing one for a processor that has none pending (and is not requested in the same write), leaves that processor's bit unchanged and pulses `warn_pulse` for the cycle after the write. Clearing a timer interrupt that is not pending raises no warning.
- R7: A cycle with `tick` high sets the timer pending bit of every processor.
- R8: When `tick` and a timer clear for the same processor fall in the same cycle, the clear wins and the bit ends low.
- R9: Dedicated registers take their mask in `reg_wdata[3:0]`: `reg_sel` = 1 clears interprocessor interrupts, `reg_sel` = 2 clears timer interrupts and `reg_sel` = 3 posts interprocessor interrupts, with the same warning rules as R6.
- R10: A dedicated-register write whose mask in bits 3:0 is zero changes no state and pulses `err_pulse` for one cycle.
- R11: While `reg_rd` is high and `reg_sel` = 0, `reg_rdata` returns the interprocessor pending vector in bits 11:8, the timer pending vector in bits 7:4 and `req_cpu` in bits 1:0, with all other bits zero; any other read returns zero, and reads change no state.
- R12: In a cycle with neither a write nor a tick, both pending vectors hold their values and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control word, 1 interprocessor clear, 2 timer clear, 3 interprocessor request |
| reg_wdata | input | 64 | Write data |
| req_cpu | input | 2 | Number of the processor issuing the access |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| reg_rdata | output | 64 | Read data, valid in the cycle `reg_rd` is high |
| ipi_irq | output | 4 | Interprocessor interrupt line per processor |
| tmr_irq | output | 4 | Timer interrupt line per processor |
| warn_pulse | output | 1 | One-cycle pulse after a redundant request or clear |
| err_pulse | output | 1 | One-cycle pulse after a write carrying no usable mask |

## Verification
The assertions take for granted that a write strobe, a select and its data are held for exactly one clock cycle and that `reg_rd` and `reg_wr` are never both high, since the read path reports state before any write of the same cycle would land. The stimulus drives every input on the falling edge, keeps read and write strobes in separate steps, and draws masks from a fixed-seed random source that deliberately zeroes whole fields often enough to reach the error, no-op and warning paths alongside directed cases for tick-versus-clear and request-versus-clear collisions.

// File: rtl/ipitmr_pkg.sv
package ipitmr_pkg;

    // Widest supported processor count; each mask field is this wide.
    localparam int unsigned CPU_MAX   = 4;
    localparam int unsigned SEL_W     = 2;

    // Control-word field positions (other blocks decode these).
    localparam int unsigned REQ_LSB    = 12;
    localparam int unsigned IPICLR_LSB = 8;
    localparam int unsigned TMRCLR_LSB = 4;
    localparam int unsigned NOP_BIT    = 28;

    // Read-back positions of the control word.
    localparam int unsigned RD_IPI_LSB = 8;
    localparam int unsigned RD_TMR_LSB = 4;
    localparam int unsigned RD_CPU_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_IPI_CLR = 2'd1,
        SEL_TMR_CLR = 2'd2,
        SEL_IPI_REQ = 2'd3
    } sel_e;

endpackage

// File: rtl/ipitmr_decode.sv
module ipitmr_decode
    import ipitmr_pkg::*;
#(
    parameter int unsigned NCPU   = 4,
    parameter int unsigned DATA_W = 64
) (
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCPU-1:0]   ipi_set,
    output logic [NCPU-1:0]   ipi_clr,
    output logic [NCPU-1:0]   tmr_clr,
    output logic              bad_wr
);

    logic [NCPU-1:0] f_req;
    logic [NCPU-1:0] f_iclr;
    logic [NCPU-1:0] f_tclr;
    logic [NCPU-1:0] f_mask;
    logic            f_nop;
    logic            unused_wdata;

    assign f_req  = wdata[REQ_LSB    +: NCPU];
    assign f_iclr = wdata[IPICLR_LSB +: NCPU];
    assign f_tclr = wdata[TMRCLR_LSB +: NCPU];
    assign f_mask = wdata[0          +: NCPU];
    assign f_nop  = wdata[NOP_BIT];
    assign unused_wdata = ^wdata;

    always_comb begin
        ipi_set = '0;
        ipi_clr = '0;
        tmr_clr = '0;
        bad_wr  = 1'b0;
        if (wr) begin
            unique case (sel_e'(sel))
                SEL_CTRL: begin
                    ipi_set = f_req;
                    ipi_clr = f_iclr;
                    tmr_clr = f_tclr;
                    bad_wr  = (f_req == '0) && (f_iclr == '0) &&
                              (f_tclr == '0) && !f_nop;
                end
                SEL_IPI_CLR: begin
                    ipi_clr = f_mask;
                    bad_wr  = (f_mask == '0);
                end
                SEL_TMR_CLR: begin
                    tmr_clr = f_mask;
                    bad_wr  = (f_mask == '0);
                end
                SEL_IPI_REQ: begin
                    ipi_set = f_mask;
                    bad_wr  = (f_mask == '0);
                end
                default: begin
                    bad_wr = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ipitmr_pend.sv
module ipitmr_pend #(
    parameter int unsigned NCPU    = 4,
    parameter bit          WARN_EN = 1'b1
) (
    input  logic [NCPU-1:0] cur,
    input  logic [NCPU-1:0] set,
    input  logic [NCPU-1:0] clr,
    output logic [NCPU-1:0] nxt,
    output logic [NCPU-1:0] redundant
);

    // Set applies first, clear last: clear wins on overlap.
    assign nxt = (cur | set) & ~clr;

    generate
        if (WARN_EN) begin : g_warn
            assign redundant = (set & cur) | (clr & ~cur & ~set);
        end else begin : g_nowarn
            assign redundant = '0;
        end
    endgenerate

endmodule

// File: rtl/ipitmr_ctl.sv
module ipitmr_ctl
    import ipitmr_pkg::*;
#(
    parameter int unsigned NCPU   = 4,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [RD_CPU_W-1:0] req_cpu,
    input  logic              tick,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   tmr_irq,
    output logic              warn_pulse,
    output logic              err_pulse
);

    localparam int unsigned FIELD_SPAN = NCPU;

    typedef struct packed {
        logic [NCPU-1:0] ipi;
        logic [NCPU-1:0] tmr;
        logic            warn;
        logic            err;
    } state_t;

    state_t st_d, st_q;

    logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr;
    logic            bad_wr;
    logic [NCPU-1:0] ipi_nxt, tmr_nxt;
    logic [NCPU-1:0] ipi_redundant;
    logic [NCPU-1:0] tmr_redundant_unused;

    ipitmr_decode #(.NCPU(NCPU), .DATA_W(DATA_W)) u_dec (
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .ipi_set (ipi_set),
        .ipi_clr (ipi_clr),
        .tmr_clr (tmr_clr),
        .bad_wr  (bad_wr)
    );

    ipitmr_pend #(.NCPU(NCPU), .WARN_EN(1'b1)) u_ipi (
        .cur       (st_q.ipi),
        .set       (ipi_set),
        .clr       (ipi_clr),
        .nxt       (ipi_nxt),
        .redundant (ipi_redundant)
    );

    ipitmr_pend #(.NCPU(NCPU), .WARN_EN(1'b0)) u_tmr (
        .cur       (st_q.tmr),
        .set       ({FIELD_SPAN{tick}}),
        .clr       (tmr_clr),
        .nxt       (tmr_nxt),
        .redundant (tmr_redundant_unused)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ipi  = ipi_nxt;
        st_d.tmr  = tmr_nxt;
        st_d.warn = |ipi_redundant;
        st_d.err  = bad_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && (sel_e'(reg_sel) == SEL_CTRL)) begin
            reg_rdata[RD_IPI_LSB +: NCPU]   = st_q.ipi;
            reg_rdata[RD_TMR_LSB +: NCPU]   = st_q.tmr;
            reg_rdata[0 +: RD_CPU_W]        = req_cpu;
        end
    end

    assign ipi_irq    = st_q.ipi;
    assign tmr_irq    = st_q.tmr;
    assign warn_pulse = st_q.warn;
    assign err_pulse  = st_q.err;

endmodule

// File: rtl/ipitmr_chk.sv
module ipitmr_chk
    import ipitmr_pkg::*;
#(
    parameter int unsigned NCPU   = 4,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              tick,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NCPU-1:0]   ipi_irq,
    input logic [NCPU-1:0]   tmr_irq,
    input logic              warn_pulse,
    input logic              err_pulse
);

    // R7
    tick_sets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reg_wr) |=> (&tmr_irq));

    // R8
    tmr_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=>
            ((tmr_irq & $past(reg_wdata[NCPU-1:0])) == '0));

    // R9
    ipi_request_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3) |=>
            ((ipi_irq & $past(reg_wdata[NCPU-1:0])) == $past(reg_wdata[NCPU-1:0])));

    // R10
    zero_mask_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel != 2'd0 && reg_wdata[NCPU-1:0] == '0) |=>
            (err_pulse && $stable(ipi_irq)));

    // R6
    redundant_req_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3 && (reg_wdata[NCPU-1:0] & ipi_irq) != '0) |=> warn_pulse);

    // R11
    read_reports_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd0) |->
            (reg_rdata[RD_IPI_LSB +: NCPU] == ipi_irq && reg_rdata[RD_TMR_LSB +: NCPU] == tmr_irq));

    // R12
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !tick) |=>
            ($stable(ipi_irq) && $stable(tmr_irq) && !warn_pulse && !err_pulse));

endmodule

bind ipitmr_ctl ipitmr_chk #(.NCPU(NCPU), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .tick       (tick),
    .reg_rdata  (reg_rdata),
    .ipi_irq    (ipi_irq),
    .tmr_irq    (tmr_irq),
    .warn_pulse (warn_pulse),
    .err_pulse  (err_pulse)
);

// File: tb/sim_ipitmr_ctl.sv
`timescale 1ns/1ps
module sim_ipitmr_ctl;

    localparam int NCPU   = 4;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [1:0]        reg_sel = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [1:0]        req_cpu = '0;
    logic              tick = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NCPU-1:0]   ipi_irq, tmr_irq;
    logic              warn_pulse, err_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0] m_ipi = '0;
    logic [3:0] m_tmr = '0;
    logic       m_warn = 1'b0;
    logic       m_err  = 1'b0;

    always #10 clk = ~clk;

    ipitmr_ctl #(.NCPU(NCPU), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .req_cpu(req_cpu),
        .tick(tick), .reg_rdata(reg_rdata), .ipi_irq(ipi_irq),
        .tmr_irq(tmr_irq), .warn_pulse(warn_pulse), .err_pulse(err_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected read-back of the control word (R11).
    function automatic logic [63:0] exp_read(input logic [1:0] sel, input logic [1:0] cpu);
        logic [63:0] v = '0;
        if (sel == 2'd0) begin
            v[11:8] = m_ipi;
            v[7:4]  = m_tmr;
            v[1:0]  = cpu;
        end
        return v;
    endfunction

    // Reference model of one clock edge from the requirements.
    task automatic model(input logic wr, input logic [1:0] sel, input logic [63:0] d, input logic tk);
        logic [3:0] rq = '0, ic = '0, tc = '0;
        logic [3:0] ni, nt;
        logic       w = 1'b0, e = 1'b0;
        if (wr) begin
            case (sel)
                2'd0: begin
                    rq = d[15:12]; ic = d[11:8]; tc = d[7:4];
                    e = (d[15:4] == '0) && !d[28];
                end
                2'd1: begin ic = d[3:0]; e = (d[3:0] == '0); end
                2'd2: begin tc = d[3:0]; e = (d[3:0] == '0); end
                default: begin rq = d[3:0]; e = (d[3:0] == '0); end
            endcase
        end
        for (int c = 0; c < 4; c++) begin
            ni[c] = m_ipi[c];
            if (rq[c]) begin
                if (m_ipi[c]) w = 1'b1;
                ni[c] = 1'b1;
            end
            if (ic[c]) begin
                if (!ni[c]) w = 1'b1;
                ni[c] = 1'b0;
            end
            nt[c] = m_tmr[c];
            if (tk) nt[c] = 1'b1;
            if (tc[c]) nt[c] = 1'b0;
        end
        m_ipi = ni; m_tmr = nt; m_warn = w; m_err = e;
    endtask

    // One cycle: drive at the falling edge, check after the next rising edge.
    task automatic step(input string tag, input logic wr, input logic rd,
                        input logic [1:0] sel, input logic [63:0] d,
                        input logic tk, input logic [1:0] cpu);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = d;
        tick = tk; req_cpu = cpu;
        #1;
        if (rd) chk({tag, " R11 rdata"}, reg_rdata, exp_read(sel, cpu));
        model(wr, sel, d, tk);
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0; tick = 1'b0;
        chk({tag, " R2 ipi"}, {60'd0, ipi_irq}, {60'd0, m_ipi});
        chk({tag, " R2 tmr"}, {60'd0, tmr_irq}, {60'd0, m_tmr});
        chk({tag, " R6 warn"}, {63'd0, warn_pulse}, {63'd0, m_warn});
        chk({tag, " R5/R10 err"}, {63'd0, err_pulse}, {63'd0, m_err});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 ipi", {60'd0, ipi_irq}, 64'd0);
        chk("R1 tmr", {60'd0, tmr_irq}, 64'd0);
        chk("R1 pulses", {62'd0, warn_pulse, err_pulse}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R3 post all", 1, 0, 2'd0, 64'h0000_F000, 0, 0);
        step("R7 tick", 0, 0, 2'd0, 0, 1, 0);
        step("R11 read cpu2", 0, 1, 2'd0, 0, 0, 2'd2);
        step("R11 read other sel", 0, 1, 2'd1, 0, 0, 2'd3);
        step("R3 combined", 1, 0, 2'd0, 64'h0000_0350, 0, 0);
        step("R4 req then clr", 1, 0, 2'd0, 64'h0000_4400, 0, 0);
        step("R5 nop bit", 1, 0, 2'd0, 64'h1000_0000, 0, 0);
        step("R5 empty ctrl", 1, 0, 2'd0, 64'h0000_0000, 0, 0);
        step("R6 redundant req", 1, 0, 2'd3, 64'h0000_0008, 0, 0);
        step("R6 clr not pending", 1, 0, 2'd1, 64'h0000_0004, 0, 0);
        step("R6 tmr clr no warn", 1, 0, 2'd2, 64'h0000_0001, 0, 0);
        step("R8 tick vs clr", 1, 0, 2'd2, 64'h0000_0006, 1, 0);
        step("R9 ipi req", 1, 0, 2'd3, 64'h0000_0005, 0, 0);
        step("R9 ipi clr", 1, 0, 2'd1, 64'h0000_000F, 0, 0);
        step("R10 zero mask", 1, 0, 2'd3, 64'hFFFF_FFF0, 0, 0);
        step("R12 idle", 0, 0, 2'd0, 64'h0000_F0F0, 0, 0);
        step("R11 read cpu1", 0, 1, 2'd0, 0, 0, 2'd1);

        for (int i = 0; i < 600; i++) begin
            logic [63:0] d;
            logic [1:0]  s;
            logic        rd;
            d  = {$urandom, $urandom};
            s  = 2'($urandom_range(0, 3));
            rd = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 2) == 0) d[15:12] = '0;
            if ($urandom_range(0, 2) == 0) d[11:8]  = '0;
            if ($urandom_range(0, 2) == 0) d[7:4]   = '0;
            if ($urandom_range(0, 3) == 0) d[3:0]   = '0;
            if ($urandom_range(0, 1) == 0) d[28]    = 1'b0;
            step("rand R3 R9", !rd && ($urandom_range(0, 1) == 1), rd, s, d,
                 ($urandom_range(0, 4) == 0), 2'($urandom));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule